// File: doc/BRIEF.md
# CPU exception entry controller

This block carries out the architectural state changes a processor core makes when it is reset or when it takes a general exception. The core supplies its current program counter, status word and vector base. On an accepted exception the block captures the PC and status word into saved copies. It raises the privilege, register-bank and exception-block bits in the status word and records a 12-bit event code. It then redirects fetch to the vector base plus one of two offsets, picked by whether the exception is a translation-miss trap. A one-cycle `flush` pulse tells the pipeline to discard in-flight work and adopt `pcOut` and `srOut`.

Two reset inputs exist. The power-on reset acts asynchronously. The manual reset is sampled on the clock. Each reset loads its own event code, clears the vector base, loads the reset status word and points fetch at the fixed reset address. While either reset is applied, the two status pins read high, and the core adopts `srOut`, `vbrOut` and `pcOut`. Exception requests that arrive while the exception-block bit of the current status word is already set are dropped. Reporting them is left to surrounding logic.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On an accepted exception, `spcOut` takes `curPc` and `ssrOut` takes `curSr` at the same clock edge. An exception is accepted when `excReq` is 1, `curSr[28]` is 0 and both resets are inactive.
- R2: After an accepted exception, `srOut` equals `curSr` with bits 30 (privileged mode), 29 (register bank) and 28 (exception block) forced to 1. All other bits keep their values.
- R3: After an accepted exception, `expevtOut[11:0]` equals `excCode` and `expevtOut[31:12]` is zero. The upper bits read zero at all times.
- R4: After an accepted exception, `pcOut` equals `curVbr + 0x400` when `excTlb` is 1, and `curVbr + 0x100` otherwise. The sum wraps modulo 2^32.
- R5: `flush` is high for exactly the one cycle following the edge that accepted an exception, and is low at every other time.
- R6: A request made while `curSr[28]` is 1 changes none of `spcOut`, `ssrOut`, `srOut`, `expevtOut`, `pcOut` and does not raise `flush`.
- R7: While `porN` is low (asynchronously), `expevtOut`=0x000, `vbrOut`=0, `srOut`=0x700000F0, `pcOut`=0xA0000000, `spcOut`=`ssrOut`=0 and `flush`=0.
- R8: At an edge where `manN` is low and `porN` high, `expevtOut`=0x020, `vbrOut`=0, `srOut`=0x700000F0 and `pcOut`=0xA0000000. `spcOut` and `ssrOut` keep their values.
- R9: `statusPins` reads 2'b11 while `porN` is low and after every edge with `manN` low. It reads 2'b00 after the first edge at which both resets are inactive.
- R10: Power-on reset wins over manual reset, and either reset wins over an exception request in the same cycle. Such a request is dropped with no `flush`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| manN | input | 1 | Manual reset, active low, sampled on the clock |
| excReq | input | 1 | General exception request |
| excTlb | input | 1 | Marks the request as a translation-miss trap |
| excCode | input | 12 | Event code of the request |
| curPc | input | 32 | Current program counter |
| curSr | input | 32 | Current status word |
| curVbr | input | 32 | Current vector base |
| spcOut | output | 32 | Saved program counter |
| ssrOut | output | 32 | Saved status word |
| srOut | output | 32 | Status word to adopt |
| vbrOut | output | 32 | Vector base to adopt during reset |
| expevtOut | output | 32 | Exception event register |
| pcOut | output | 32 | Next fetch address |
| flush | output | 1 | One-cycle pipeline flush and redirect |
| statusPins | output | 2 | Reset status pins |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 12-bit event code, the status bits at 30/29/28 and the mask field at bits 7:4. This lets concrete status words and reset constants be compared exactly. With a 32-bit address, a vector base of 0xFFFFFF00 becomes reachable, so the wrap of the vector sum to zero can be observed. The 12-bit code width lets the all-ones code 0xFFF show that nothing spills into the upper event-register bits.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic manRst;   // manual reset applied this edge
    logic excTake;  // exception accepted this edge
    logic tlbSel;   // pick the translation-miss offset
  } ctlStrobes_t;

endpackage

// File: rtl/exc_entry_ctl.sv
module exc_entry_ctl
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int BL_POS = 28
) (
  input  logic            manN,
  input  logic            excReq,
  input  logic            excTlb,
  input  logic [XLEN-1:0] curSr,
  output ctlStrobes_t     strobes
);

  logic blocked;

  always_comb begin
    blocked         = curSr[BL_POS];
    strobes.manRst  = ~manN;
    // manual reset outranks an exception; blocked requests are dropped
    strobes.excTake = manN & excReq & ~blocked;
    strobes.tlbSel  = excTlb;
  end

endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              CODE_W    = 12,
  parameter int              BL_POS    = 28,
  parameter int              RB_POS    = 29,
  parameter int              MD_POS    = 30,
  parameter int              IMASK_LSB = 4,
  parameter int              IMASK_W   = 4,
  parameter logic [XLEN-1:0] RESET_PC  = 32'hA000_0000,
  parameter logic [XLEN-1:0] OFS_TLB   = 32'h0000_0400,
  parameter logic [XLEN-1:0] OFS_GEN   = 32'h0000_0100,
  parameter logic [CODE_W-1:0] POR_CODE = 12'h000,
  parameter logic [CODE_W-1:0] MAN_CODE = 12'h020
) (
  input  logic              clk,
  input  logic              porN,
  input  ctlStrobes_t       strobes,
  input  logic [CODE_W-1:0] excCode,
  input  logic [XLEN-1:0]   curPc,
  input  logic [XLEN-1:0]   curSr,
  input  logic [XLEN-1:0]   curVbr,
  output logic [XLEN-1:0]   spcOut,
  output logic [XLEN-1:0]   ssrOut,
  output logic [XLEN-1:0]   srOut,
  output logic [XLEN-1:0]   vbrOut,
  output logic [XLEN-1:0]   expevtOut,
  output logic [XLEN-1:0]   pcOut,
  output logic              flush,
  output logic [1:0]        statusPins
);

  localparam int PAD_W = XLEN - CODE_W;
  localparam logic [XLEN-1:0] ONE      = {{(XLEN-1){1'b0}}, 1'b1};
  localparam logic [XLEN-1:0] ENTRY_OR = (ONE << MD_POS) | (ONE << RB_POS) | (ONE << BL_POS);
  localparam logic [XLEN-1:0] IMASK    = {{(XLEN-IMASK_W){1'b0}}, {IMASK_W{1'b1}}} << IMASK_LSB;
  localparam logic [XLEN-1:0] SR_RST   = ENTRY_OR | IMASK;

  logic [XLEN-1:0]   codeCode;
  logic [XLEN-1:0]   vecPc;
  logic [CODE_W-1:0] codeField;

  always_comb begin
    vecPc     = curVbr + (strobes.tlbSel ? OFS_TLB : OFS_GEN);
    codeField = excCode;
    codeCode  = {{PAD_W{1'b0}}, codeField};
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      spcOut     <= '0;
      ssrOut     <= '0;
      srOut      <= SR_RST;
      vbrOut     <= '0;
      expevtOut  <= {{PAD_W{1'b0}}, POR_CODE};
      pcOut      <= RESET_PC;
      flush      <= 1'b0;
      statusPins <= 2'b11;
    end else if (strobes.manRst) begin
      srOut      <= SR_RST;
      vbrOut     <= '0;
      expevtOut  <= {{PAD_W{1'b0}}, MAN_CODE};
      pcOut      <= RESET_PC;
      flush      <= 1'b0;
      statusPins <= 2'b11;
    end else begin
      statusPins <= 2'b00;
      flush      <= strobes.excTake;
      if (strobes.excTake) begin
        spcOut    <= curPc;
        ssrOut    <= curSr;
        srOut     <= curSr | ENTRY_OR;
        expevtOut <= codeCode;
        pcOut     <= vecPc;
      end
    end
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              CODE_W    = 12,
  parameter int              BL_POS    = 28,
  parameter int              RB_POS    = 29,
  parameter int              MD_POS    = 30,
  parameter int              IMASK_LSB = 4,
  parameter int              IMASK_W   = 4,
  parameter logic [XLEN-1:0] RESET_PC  = 32'hA000_0000,
  parameter logic [XLEN-1:0] OFS_TLB   = 32'h0000_0400,
  parameter logic [XLEN-1:0] OFS_GEN   = 32'h0000_0100,
  parameter logic [CODE_W-1:0] POR_CODE = 12'h000,
  parameter logic [CODE_W-1:0] MAN_CODE = 12'h020
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              manN,
  input  logic              excReq,
  input  logic              excTlb,
  input  logic [CODE_W-1:0] excCode,
  input  logic [XLEN-1:0]   curPc,
  input  logic [XLEN-1:0]   curSr,
  input  logic [XLEN-1:0]   curVbr,
  output logic [XLEN-1:0]   spcOut,
  output logic [XLEN-1:0]   ssrOut,
  output logic [XLEN-1:0]   srOut,
  output logic [XLEN-1:0]   vbrOut,
  output logic [XLEN-1:0]   expevtOut,
  output logic [XLEN-1:0]   pcOut,
  output logic              flush,
  output logic [1:0]        statusPins
);

  ctlStrobes_t strobes;

  exc_entry_ctl #(.XLEN(XLEN), .BL_POS(BL_POS)) u_ctl (
    .manN    (manN),
    .excReq  (excReq),
    .excTlb  (excTlb),
    .curSr   (curSr),
    .strobes (strobes)
  );

  exc_entry_dp #(
    .XLEN(XLEN), .CODE_W(CODE_W), .BL_POS(BL_POS), .RB_POS(RB_POS),
    .MD_POS(MD_POS), .IMASK_LSB(IMASK_LSB), .IMASK_W(IMASK_W),
    .RESET_PC(RESET_PC), .OFS_TLB(OFS_TLB), .OFS_GEN(OFS_GEN),
    .POR_CODE(POR_CODE), .MAN_CODE(MAN_CODE)
  ) u_dp (
    .clk        (clk),
    .porN       (porN),
    .strobes    (strobes),
    .excCode    (excCode),
    .curPc      (curPc),
    .curSr      (curSr),
    .curVbr     (curVbr),
    .spcOut     (spcOut),
    .ssrOut     (ssrOut),
    .srOut      (srOut),
    .vbrOut     (vbrOut),
    .expevtOut  (expevtOut),
    .pcOut      (pcOut),
    .flush      (flush),
    .statusPins (statusPins)
  );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int              XLEN     = 32,
  parameter int              CODE_W   = 12,
  parameter int              BL_POS   = 28,
  parameter int              RB_POS   = 29,
  parameter int              MD_POS   = 30,
  parameter logic [XLEN-1:0] RESET_PC = 32'hA000_0000,
  parameter logic [CODE_W-1:0] MAN_CODE = 12'h020
) (
  input logic              clk,
  input logic              porN,
  input logic              manN,
  input logic              excReq,
  input logic [XLEN-1:0]   curPc,
  input logic [XLEN-1:0]   curSr,
  input logic [XLEN-1:0]   spcOut,
  input logic [XLEN-1:0]   ssrOut,
  input logic [XLEN-1:0]   srOut,
  input logic [XLEN-1:0]   expevtOut,
  input logic [XLEN-1:0]   pcOut,
  input logic              flush,
  input logic [1:0]        statusPins
);

  logic takeNow;
  assign takeNow = excReq && !curSr[BL_POS] && manN;

  AST_SAVE_PC: assert property (@(posedge clk) disable iff (!porN)
    takeNow |=> (spcOut == $past(curPc)) && (ssrOut == $past(curSr))); // R1
  AST_ENTRY_BITS: assert property (@(posedge clk) disable iff (!porN)
    takeNow |=> srOut[BL_POS] && srOut[RB_POS] && srOut[MD_POS]); // R2
  AST_CODE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!porN)
    expevtOut[XLEN-1:CODE_W] == '0); // R3
  AST_FLUSH_ONLY_ON_TAKE: assert property (@(posedge clk) disable iff (!porN)
    !takeNow |=> !flush); // R5
  AST_BLOCKED_DROP: assert property (@(posedge clk) disable iff (!porN)
    (manN && curSr[BL_POS]) |=> $stable(spcOut) && $stable(pcOut) && !flush); // R6
  AST_MAN_RESET_LOAD: assert property (@(posedge clk) disable iff (!porN)
    !manN |=> (expevtOut[CODE_W-1:0] == MAN_CODE) && (pcOut == RESET_PC) && $stable(spcOut)); // R8
  AST_STATUS_HIGH: assert property (@(posedge clk) disable iff (!porN)
    !manN |=> statusPins == 2'b11); // R9
  AST_STATUS_LOW: assert property (@(posedge clk) disable iff (!porN)
    manN |=> statusPins == 2'b00); // R9
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!porN)
    (!manN && excReq) |=> !flush); // R10

endmodule

bind exc_entry_ctrl exc_entry_chk #(
  .XLEN(XLEN), .CODE_W(CODE_W), .BL_POS(BL_POS), .RB_POS(RB_POS),
  .MD_POS(MD_POS), .RESET_PC(RESET_PC), .MAN_CODE(MAN_CODE)
) u_chk (
  .clk(clk), .porN(porN), .manN(manN), .excReq(excReq),
  .curPc(curPc), .curSr(curSr), .spcOut(spcOut), .ssrOut(ssrOut),
  .srOut(srOut), .expevtOut(expevtOut), .pcOut(pcOut),
  .flush(flush), .statusPins(statusPins)
);

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;

  logic        clk = 1'b0;
  logic        porN, manN, excReq, excTlb;
  logic [11:0] excCode;
  logic [31:0] curPc, curSr, curVbr;
  logic [31:0] spcOut, ssrOut, srOut, vbrOut, expevtOut, pcOut;
  logic        flush;
  logic [1:0]  statusPins;

  int nChk = 0;
  int nBad = 0;

  localparam logic [31:0] SR_RST = 32'h7000_00F0;
  localparam logic [31:0] RST_PC = 32'hA000_0000;

  always #4 clk = ~clk;  // 125 MHz

  exc_entry_ctrl u0 (
    .clk(clk), .porN(porN), .manN(manN), .excReq(excReq), .excTlb(excTlb),
    .excCode(excCode), .curPc(curPc), .curSr(curSr), .curVbr(curVbr),
    .spcOut(spcOut), .ssrOut(ssrOut), .srOut(srOut), .vbrOut(vbrOut),
    .expevtOut(expevtOut), .pcOut(pcOut), .flush(flush), .statusPins(statusPins)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tPor();
    @(negedge clk);
    porN = 1'b0; manN = 1'b1; excReq = 1'b0;
    #1;
    chk("R7 expevt", expevtOut, 32'h0);
    chk("R7 vbr", vbrOut, 32'h0);
    chk("R7 sr", srOut, SR_RST);
    chk("R7 pc", pcOut, RST_PC);
    chk("R7 spc", spcOut, 32'h0);
    chk("R7 ssr", ssrOut, 32'h0);
    chk("R7 flush", {31'b0, flush}, 32'h0);
    chk("R9 pins por", {30'b0, statusPins}, 32'h3);
    @(negedge clk);
    porN = 1'b1;
    @(negedge clk);
    chk("R9 pins after por", {30'b0, statusPins}, 32'h0);
  endtask

  task automatic tExc(input logic tlb, input logic [11:0] code, input logic [31:0] pc,
                      input logic [31:0] sr, input logic [31:0] vbr, input logic [31:0] expPc);
    @(negedge clk);
    excReq = 1'b1; excTlb = tlb; excCode = code; curPc = pc; curSr = sr; curVbr = vbr;
    @(negedge clk);
    excReq = 1'b0;
    chk("R1 spc", spcOut, pc);
    chk("R1 ssr", ssrOut, sr);
    chk("R2 sr", srOut, sr | 32'h7000_0000);
    chk("R3 expevt", expevtOut, {20'h0, code});
    chk("R4 pc", pcOut, expPc);
    chk("R5 flush high", {31'b0, flush}, 32'h1);
    @(negedge clk);
    chk("R5 flush low", {31'b0, flush}, 32'h0);
  endtask

  task automatic tBlocked();
    logic [31:0] sSpc, sSsr, sSr, sEv, sPc;
    sSpc = spcOut; sSsr = ssrOut; sSr = srOut; sEv = expevtOut; sPc = pcOut;
    @(negedge clk);
    excReq = 1'b1; excTlb = 1'b0; excCode = 12'h555; curPc = 32'h1111_2222;
    curSr = 32'h1000_0000; curVbr = 32'h0000_8000;
    @(negedge clk);
    excReq = 1'b0;
    chk("R6 spc", spcOut, sSpc);
    chk("R6 ssr", ssrOut, sSsr);
    chk("R6 sr", srOut, sSr);
    chk("R6 expevt", expevtOut, sEv);
    chk("R6 pc", pcOut, sPc);
    chk("R6 flush", {31'b0, flush}, 32'h0);
  endtask

  task automatic tManual();
    logic [31:0] sSpc, sSsr;
    sSpc = spcOut; sSsr = ssrOut;
    @(negedge clk);
    manN = 1'b0; excReq = 1'b1; curSr = 32'h0; curPc = 32'h2222_0000; curVbr = 32'h4000_0000;
    @(negedge clk);
    chk("R8 expevt", expevtOut, 32'h20);
    chk("R8 vbr", vbrOut, 32'h0);
    chk("R8 sr", srOut, SR_RST);
    chk("R8 pc", pcOut, RST_PC);
    chk("R8 spc kept", spcOut, sSpc);
    chk("R8 ssr kept", ssrOut, sSsr);
    chk("R10 no flush under reset", {31'b0, flush}, 32'h0);
    chk("R9 pins manual", {30'b0, statusPins}, 32'h3);
    excReq = 1'b0; manN = 1'b1;
    @(negedge clk);
    chk("R9 pins after manual", {30'b0, statusPins}, 32'h0);
  endtask

  task automatic tBoth();
    @(negedge clk);
    porN = 1'b0; manN = 1'b0;
    #1;
    chk("R10 por over manual", expevtOut, 32'h0);
    @(negedge clk);
    porN = 1'b1;
    @(negedge clk);
    chk("R10 manual after por release", expevtOut, 32'h20);
    manN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    porN = 1'b1; manN = 1'b1; excReq = 1'b0; excTlb = 1'b0; excCode = '0;
    curPc = '0; curSr = '0; curVbr = '0;
    tPor();
    tExc(1'b0, 12'hABC, 32'h8C00_1234, 32'h0000_00F3, 32'h8C00_0000, 32'h8C00_0100);
    tExc(1'b1, 12'hFFF, 32'h0C00_4000, 32'h0000_03F0, 32'h1234_0000, 32'h1234_0400);
    tExc(1'b0, 12'h040, 32'h0000_0010, 32'h8000_0001, 32'hFFFF_FF00, 32'h0000_0000);
    tBlocked();
    tManual();
    tBoth();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule